// File: doc/BRIEF.md
# Four-Lane Flagged Byte Multiplier

This block forms four byte products side by side. Each operand digit is an unsigned byte paired with a one-bit flag, and a mode input sets how the flag is read. In carry mode the flag adds one to the byte, so a digit lies in 0..256. In borrow mode the flag subtracts one, so a digit lies in -1..255. Every lane returns a two-byte product and an outgoing flag. The outgoing flag holds the part of the product that two bytes cannot hold, or the sign of the product.

A built-in sequencer takes two four-digit operands and emits all sixteen digit products in four back-to-back steps. Between steps it rotates the lanes of the second operand by one position. Each emitted product is tagged with the result column it belongs to, which is the sum of the two digit indices. Adding the tagged products into columns is left to the logic downstream.

Top module: `fmul4_top`

## Requirements
- R1: In carry mode (`mode`=0) a digit's value is byte + flag. When the lane product P is below 65536, the lane gives `{hi,lo}` = P with its flag clear.
- R2: In carry mode a lane product of exactly 65536 (both digits 256) is given as lo = 0, hi = 0 and flag = 1. The flag is worth +65536.
- R3: In borrow mode (`mode`=1) a digit's value is byte − flag. A non-negative lane product P is given as `{hi,lo}` = P with the flag clear.
- R4: In borrow mode a negative lane product P is given as `{hi,lo}` = P + 256 with the flag set. The flag is worth −256, so hi is 0 and lo is non-zero.
- R5: A `start` seen while idle latches both operands, their flags and the mode. `busy` rises on that clock edge, and the first result appears with `valid` on the next edge.
- R6: In step s (0..3), lane i multiplies digit i of A by digit (i+s) mod 4 of B. The flag of each B digit moves with its byte. The lane's column tag is i + ((i+s) mod 4).
- R7: `valid` is high for exactly four consecutive cycles per operation. `done` is high only with the fourth one, and `busy` falls on that same edge.
- R8: While `busy` is high, `start`, `mode` and the operand inputs have no effect on the results being produced.
- R9: The sixteen tagged products, each weighted by 256^column, add up to the exact product of the two four-digit operands in either mode.
- R10: While reset is applied, and right after it, `busy`, `valid`, `done` and all product outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| mode | input | 1 | 0 = carry digits, 1 = borrow digits |
| a_byte | input | 32 | Operand A bytes, digit i in bits 8i+7:8i |
| a_flag | input | 4 | Operand A flags, bit i goes with digit i |
| b_byte | input | 32 | Operand B bytes, digit i in bits 8i+7:8i |
| b_flag | input | 4 | Operand B flags, bit i goes with digit i |
| busy | output | 1 | Operation in progress |
| valid | output | 1 | Lane outputs hold one step of products |
| done | output | 1 | Marks the last step of an operation |
| p_lo | output | 32 | Lane product low bytes, lane i in bits 8i+7:8i |
| p_hi | output | 32 | Lane product high bytes, lane i in bits 8i+7:8i |
| p_flag | output | 4 | Lane outgoing flags |
| p_col | output | 12 | Lane column tags, lane i in bits 3i+2:3i |

## Verification
The assertions assume that reset is applied before the first start and that `start` and `mode` are never unknown at a clock edge. They also read the mode that was latched, not the live pin, so they stay valid when the `mode` pin moves during an operation. The stimulus drives every input half a cycle away from the active edge. It uses full-range bytes with every flag pattern, and it changes `mode` and the operands on purpose only while the unit is busy, which is exactly where R8 says the change must have no effect.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
   typedef enum logic {
      FM_CARRY  = 1'b0,
      FM_BORROW = 1'b1
   } fmul_mode_e;
endpackage

// File: rtl/fmul_lane.sv
module fmul_lane
   import fmul_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  fmul_mode_e        mode,
   input  logic [BYTE_W-1:0] a,
   input  logic              a_flag,
   input  logic [BYTE_W-1:0] b,
   input  logic              b_flag,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              flag
);
   localparam int XW = BYTE_W + 2;
   localparam int PW = 2 * XW;
   localparam logic signed [PW-1:0] BASE = PW'(1) << BYTE_W;

   logic signed [XW-1:0] xa, xb;
   logic signed [PW-1:0] prod, adj;

   // digit values: byte +/- flag depending on mode
   always_comb begin
      xa = $signed({2'b00, a});
      xb = $signed({2'b00, b});
      if (a_flag) xa = (mode == FM_BORROW) ? xa - XW'(1) : xa + XW'(1);
      if (b_flag) xb = (mode == FM_BORROW) ? xb - XW'(1) : xb + XW'(1);
      prod = xa * xb;
   end

   // encode product into two bytes plus signed outgoing flag
   always_comb begin
      if (mode == FM_BORROW) begin
         flag = prod[PW-1];
         adj  = flag ? prod + BASE : prod;
      end else begin
         flag = prod[2*BYTE_W];
         adj  = prod;
      end
      {hi, lo} = adj[2*BYTE_W-1:0];
   end
endmodule

// File: rtl/fmul_seq.sv
module fmul_seq #(
   parameter int STEPS = 4,
   localparam int SW = (STEPS > 2) ? $clog2(STEPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          load,
   output logic          adv,
   output logic          last,
   output logic [SW-1:0] step
);
   assign load = start && !busy;
   assign adv  = busy;
   assign last = busy && (step == SW'(STEPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
      end else if (load) begin
         busy <= 1'b1;
         step <= '0;
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
            step <= '0;
         end else begin
            step <= step + SW'(1);
         end
      end
   end
endmodule

// File: rtl/fmul4_top.sv
module fmul4_top
   import fmul_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int OPW = LANES * BYTE_W,
   localparam int CW  = $clog2(2 * LANES - 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                mode,
   input  logic [OPW-1:0]      a_byte,
   input  logic [LANES-1:0]    a_flag,
   input  logic [OPW-1:0]      b_byte,
   input  logic [LANES-1:0]    b_flag,
   output logic                busy,
   output logic                valid,
   output logic                done,
   output logic [OPW-1:0]      p_lo,
   output logic [OPW-1:0]      p_hi,
   output logic [LANES-1:0]    p_flag,
   output logic [LANES*CW-1:0] p_col
);
   localparam int SW = (LANES > 2) ? $clog2(LANES) : 1;

   if (LANES < 2) begin : g_bad_lanes
      $error("fmul4_top: LANES must be at least 2");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("fmul4_top: BYTE_W must be at least 2");
   end

   logic          load, adv, last;
   logic [SW-1:0] step;

   fmul_seq #(.STEPS(LANES)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (busy),
      .load (load),
      .adv  (adv),
      .last (last),
      .step (step)
   );

   fmul_mode_e     mode_q;
   logic [OPW-1:0] a_q, b_q;
   logic [LANES-1:0] af_q, bf_q;

   // operand latch; B lanes rotate down by one after each step
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= FM_CARRY;
         a_q    <= '0;
         b_q    <= '0;
         af_q   <= '0;
         bf_q   <= '0;
      end else if (load) begin
         mode_q <= fmul_mode_e'(mode);
         a_q    <= a_byte;
         b_q    <= b_byte;
         af_q   <= a_flag;
         bf_q   <= b_flag;
      end else if (adv) begin
         b_q  <= {b_q[BYTE_W-1:0], b_q[OPW-1:BYTE_W]};
         bf_q <= {bf_q[0], bf_q[LANES-1:1]};
      end
   end

   logic [OPW-1:0]      lo_w, hi_w;
   logic [LANES-1:0]    fl_w;
   logic [LANES*CW-1:0] col_w;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fmul_lane #(.BYTE_W(BYTE_W)) u_lane (
         .mode  (mode_q),
         .a     (a_q[i*BYTE_W +: BYTE_W]),
         .a_flag(af_q[i]),
         .b     (b_q[i*BYTE_W +: BYTE_W]),
         .b_flag(bf_q[i]),
         .lo    (lo_w[i*BYTE_W +: BYTE_W]),
         .hi    (hi_w[i*BYTE_W +: BYTE_W]),
         .flag  (fl_w[i])
      );
      assign col_w[i*CW +: CW] = CW'(i + ((i + int'(step)) % LANES));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         done   <= 1'b0;
         p_lo   <= '0;
         p_hi   <= '0;
         p_flag <= '0;
         p_col  <= '0;
      end else begin
         valid <= adv;
         done  <= last;
         if (adv) begin
            p_lo   <= lo_w;
            p_hi   <= hi_w;
            p_flag <= fl_w;
            p_col  <= col_w;
         end
      end
   end
endmodule

// File: rtl/fmul4_chk.sv
module fmul4_chk #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int OPW = LANES * BYTE_W,
   localparam int CW  = $clog2(2 * LANES - 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                valid,
   input logic                done,
   input logic                mode_q,
   input logic [OPW-1:0]      p_lo,
   input logic [OPW-1:0]      p_hi,
   input logic [LANES-1:0]    p_flag,
   input logic [LANES*CW-1:0] p_col
);
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R5
   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (valid && !busy)); // R7
   AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(busy)); // R7
   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q)); // R8

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && !mode_q && p_flag[i]) |->
         (p_lo[i*BYTE_W +: BYTE_W] == '0 && p_hi[i*BYTE_W +: BYTE_W] == '0)); // R2
      AST_BORROW_NEG: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && mode_q && p_flag[i]) |->
         (p_hi[i*BYTE_W +: BYTE_W] == '0 && p_lo[i*BYTE_W +: BYTE_W] != '0)); // R4
      AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         valid |-> (int'(p_col[i*CW +: CW]) <= 2 * (LANES - 1))); // R6
   end
endmodule

bind fmul4_top fmul4_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .valid (valid),
   .done  (done),
   .mode_q(mode_q),
   .p_lo  (p_lo),
   .p_hi  (p_hi),
   .p_flag(p_flag),
   .p_col (p_col)
);

// File: tb/tb_fmul4_top.sv
`timescale 1ns/1ps
module tb_fmul4_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode = 1'b0;
   logic [31:0] a_byte = '0, b_byte = '0;
   logic [3:0]  a_flag = '0, b_flag = '0;
   logic        busy, valid, done;
   logic [31:0] p_lo, p_hi;
   logic [3:0]  p_flag;
   logic [11:0] p_col;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   fmul4_top dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .a_byte(a_byte), .a_flag(a_flag), .b_byte(b_byte), .b_flag(b_flag),
      .busy(busy), .valid(valid), .done(done),
      .p_lo(p_lo), .p_hi(p_hi), .p_flag(p_flag), .p_col(p_col)
   );

   // {mode, a_byte, a_flag, b_byte, b_flag}
   localparam logic [72:0] VECS [8] = '{
      {1'b0, 32'h04030201, 4'h0, 32'h08070605, 4'h0},
      {1'b0, 32'hFFFFFFFF, 4'hF, 32'hFFFFFFFF, 4'hF},
      {1'b0, 32'h12345678, 4'h5, 32'h9ABCDEF0, 4'hA},
      {1'b1, 32'h00000000, 4'hF, 32'h05FF0003, 4'h0},
      {1'b1, 32'h00000000, 4'hF, 32'h00000000, 4'hF},
      {1'b1, 32'hFF00FF00, 4'hA, 32'h01FF7F80, 4'h3},
      {1'b1, 32'hDEADBEEF, 4'h6, 32'h0BADF00D, 4'h9},
      {1'b0, 32'h00000000, 4'h0, 32'hFFFFFFFF, 4'hF}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic longint digit(input bit m, input int by, input bit f);
      return m ? longint'(by) - longint'(f) : longint'(by) + longint'(f);
   endfunction

   // expected {flag, hi, lo} for one lane
   function automatic logic [16:0] lane_exp(input bit m, input longint x, input longint y);
      longint p = x * y;
      longint v;
      bit fl;
      if (!m) begin
         fl = (p == 65536);
         v  = fl ? 0 : p;
      end else begin
         fl = (p < 0);
         v  = fl ? p + 256 : p;
      end
      return {fl, v[15:0]};
   endfunction

   task automatic run_op(input logic [72:0] vec, input bit poke);
      bit m = vec[72];
      logic [31:0] a = vec[71:40], b = vec[35:4];
      logic [3:0]  af = vec[39:36], bf = vec[3:0];
      logic signed [95:0] acc = '0, ea = '0, eb = '0, ex;
      for (int k = 0; k < 4; k++) begin
         ea = ea + ($signed(96'(digit(m, int'(a[8*k +: 8]), af[k]))) <<< (8 * k));
         eb = eb + ($signed(96'(digit(m, int'(b[8*k +: 8]), bf[k]))) <<< (8 * k));
      end
      ex = ea * eb;
      @(negedge clk);
      mode = m; a_byte = a; b_byte = b; a_flag = af; b_flag = bf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !valid, "R5", "busy/valid after start", {busy, valid}, 2'b10);
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         check(valid && (done == (s == 3)) && (busy == (s != 3)), "R7",
               $sformatf("valid/done/busy step %0d", s),
               {valid, done, busy}, {1'b1, s == 3, s != 3});
         for (int i = 0; i < 4; i++) begin
            int j = (i + s) % 4;
            logic [16:0] e = lane_exp(m, digit(m, int'(a[8*i +: 8]), af[i]),
                                         digit(m, int'(b[8*j +: 8]), bf[j]));
            logic [16:0] got = {p_flag[i], p_hi[8*i +: 8], p_lo[8*i +: 8]};
            string rq = poke ? "R8" : (!m ? (e[16] ? "R2" : "R1") : (e[16] ? "R4" : "R3"));
            longint pv;
            check(got == e, rq, $sformatf("lane %0d step %0d product", i, s), got, e);
            check(int'(p_col[3*i +: 3]) == i + j, "R6",
                  $sformatf("lane %0d step %0d column", i, s), p_col[3*i +: 3], i + j);
            pv = longint'(p_lo[8*i +: 8]) + 256 * longint'(p_hi[8*i +: 8]);
            if (p_flag[i]) pv = pv + (m ? -256 : 65536);
            acc = acc + ($signed(96'(pv)) <<< (8 * int'(p_col[3*i +: 3])));
         end
         if (poke && s == 0) begin
            mode = ~m; a_byte = ~a; b_byte = b ^ 32'h5A5A5A5A; a_flag = ~af; start = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      check(acc == ex, "R9", "reconstructed full product", longint'(acc), longint'(ex));
      @(negedge clk);
      check(!valid && !busy && !done, "R7", "idle after four steps",
            {valid, busy, done}, 3'b000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R7 watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check({busy, valid, done, p_lo, p_hi, p_flag, p_col} == '0, "R10",
            "outputs during reset", {p_flag, p_col}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !valid && !done && p_lo == 0 && p_hi == 0, "R10",
            "outputs after reset", {busy, valid, done}, 0);
      foreach (VECS[v]) run_op(VECS[v], 1'b0);
      // corner: start, mode and operands moved while busy (R8)
      run_op({1'b1, 32'h80FF0001, 4'h9, 32'h00FF02FF, 4'h6}, 1'b1);
      run_op({1'b0, 32'hFF00FFFF, 4'h5, 32'hFFFF00FF, 4'hB}, 1'b1);
      // corner: a single borrow lane of -1 * 255
      run_op({1'b1, 32'h00000000, 4'h1, 32'h000000FF, 4'h0}, 1'b0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule